// File: doc/BRIEF.md
# Two-Drive Condition Status Register

This block holds an eight-bit condition word for each of two disk drives. A sequencer reports events such as a seek starting or ending, a data overrun, an address fault, an end-of-cylinder condition, a flagged record or a drive identity condition. Each event carries the index of the drive it concerns. The block also watches a per-drive "present" level, which shows whether a drive is installed, and reflects changes of that level in the not-ready bit.

A status check is a one-cycle read request with a drive index. One cycle later the block returns that drive's word, with bit 0 filled in as a computed summary of the serious conditions. The same clock edge that serves the read also clears the transient condition bits of that drive. The persistent ones are left as they are.

Top module: `dsr_status_top`

## Requirements
- R1: The status word uses these bit positions: 7 drive identity, 6 not ready, 5 end of cylinder, 4 address error, 3 flagged, 2 busy (seeking), 1 data error, 0 summary. Bit 0 is never stored. It exists only in the returned word.
- R2: In the returned word, bit 0 is the OR of bits 7, 6, 5, 3 and 1 (mask 0xEA). The address error bit 4 does not contribute to it.
- R3: A read of a drive clears that drive's bits 5, 4, 3 and 1 (mask 0x3A) on the same edge. Bits 7, 6 and 2 are kept.
- R4: Event code 1 (seek or recalibrate started) sets busy bit 2. Event code 2 (that operation completed) clears it.
- R5: Event code 3 (data-channel overrun) sets data error bit 1.
- R6: Each of the following event codes sets one bit: code 4 sets end of cylinder bit 5, code 5 sets address error bit 4, code 6 sets flagged bit 3, and code 7 sets drive identity bit 7. Code 0 does nothing.
- R7: While reset is high, each drive's word becomes 0x00 if its present input is 1 and 0x40 otherwise.
- R8: A falling present input sets not-ready bit 6 of that drive one cycle later. A rising present input clears it.
- R9: An event or a read changes only the drive named by its index. The other drive's word is unchanged.
- R10: rd_vld and rd_data are registered and appear one cycle after rd_req. If an event for the same drive coincides with the read, the read returns the pre-event word and the event's effect survives the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drv_present | input | NDRV | Per-drive installed level |
| ev_vld | input | 1 | Event strobe |
| ev_drv | input | DW | Drive index of the event |
| ev_code | input | 3 | Event code (see R4 to R6) |
| rd_req | input | 1 | Status check request |
| rd_drv | input | DW | Drive index of the status check |
| rd_vld | output | 1 | Returned word valid, one cycle after rd_req |
| rd_data | output | 8 | Returned status word with summary bit |

## Verification
Every event, presence change and read-clear takes effect on the first rising edge after the input is presented. The returned word appears on rd_data right after that same edge. The bench drives each stimulus on a falling edge and samples the result at the next falling edge, so every check lands exactly one register stage after its cause. The sweep covers all 64 combinations of settable bits on both drives. For each one it checks the first read, the cleared second read and the other drive. It also checks a read and an event that coincide on the same edge, to confirm that the read returns the pre-event word while the event still takes effect.

// File: rtl/dsr_pkg.sv
`timescale 1ns/1ps
package dsr_pkg;
  localparam int SW = 8;

  localparam int B_DID  = 7;
  localparam int B_NRDY = 6;
  localparam int B_EOC  = 5;
  localparam int B_AER  = 4;
  localparam int B_FLG  = 3;
  localparam int B_BSY  = 2;
  localparam int B_DTE  = 1;
  localparam int B_SUM  = 0;

  localparam logic [SW-1:0] SUM_MASK  = 8'hEA;
  localparam logic [SW-1:0] CLR_MASK  = 8'h3A;
  localparam logic [SW-1:0] NRDY_WORD = 8'h40;

  typedef enum logic [2:0] {
    EV_NONE     = 3'd0,
    EV_SEEK_GO  = 3'd1,
    EV_SEEK_END = 3'd2,
    EV_OVERRUN  = 3'd3,
    EV_END_CYL  = 3'd4,
    EV_ADDR_ERR = 3'd5,
    EV_FLAGGED  = 3'd6,
    EV_DRIVE_ID = 3'd7
  } ev_code_e;
endpackage

// File: rtl/dsr_drive_reg.sv
`timescale 1ns/1ps
module dsr_drive_reg
  import dsr_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          present,
  input  logic          ev_hit,
  input  ev_code_e      ev_code,
  input  logic          rd_hit,
  output logic [SW-1:0] stat
);
  logic          present_q;
  logic [SW-1:0] nxt;

  always_comb begin
    nxt = stat;
    if (rd_hit) nxt = nxt & ~CLR_MASK;
    if (present_q && !present) nxt[B_NRDY] = 1'b1;
    if (!present_q && present) nxt[B_NRDY] = 1'b0;
    if (ev_hit) begin
      unique case (ev_code)
        EV_SEEK_GO:  nxt[B_BSY] = 1'b1;
        EV_SEEK_END: nxt[B_BSY] = 1'b0;
        EV_OVERRUN:  nxt[B_DTE] = 1'b1;
        EV_END_CYL:  nxt[B_EOC] = 1'b1;
        EV_ADDR_ERR: nxt[B_AER] = 1'b1;
        EV_FLAGGED:  nxt[B_FLG] = 1'b1;
        EV_DRIVE_ID: nxt[B_DID] = 1'b1;
        default:     ;
      endcase
    end
    nxt[B_SUM] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat      <= present ? '0 : NRDY_WORD;
      present_q <= present;
    end else begin
      stat      <= nxt;
      present_q <= present;
    end
  end

  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    rd_hit && !ev_hit |=> (stat & CLR_MASK) == '0); // R3
  AST_RD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    rd_hit && !ev_hit && (present == present_q) |=>
      stat[B_DID] == $past(stat[B_DID]) && stat[B_NRDY] == $past(stat[B_NRDY])
      && stat[B_BSY] == $past(stat[B_BSY])); // R3
  AST_BUSY_SET: assert property (@(posedge clk) disable iff (rst)
    ev_hit && ev_code == EV_SEEK_GO |=> stat[B_BSY]); // R4
  AST_NRDY_REMOVE: assert property (@(posedge clk) disable iff (rst)
    present_q && !present |=> stat[B_NRDY]); // R8
endmodule

// File: rtl/dsr_read_port.sv
`timescale 1ns/1ps
module dsr_read_port
  import dsr_pkg::*;
#(
  parameter int NDRV = 2,
  parameter int DW   = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_req,
  input  logic [DW-1:0]            rd_drv,
  input  logic [NDRV-1:0][SW-1:0]  stat_all,
  output logic                     rd_vld,
  output logic [SW-1:0]            rd_data
);
  logic [SW-1:0] sel;
  logic [SW-1:0] word;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NDRV; i++)
      if (rd_drv == DW'(i)) sel = stat_all[i];
    word        = sel;
    word[B_SUM] = |(sel & SUM_MASK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_vld  <= rd_req;
      rd_data <= rd_req ? word : rd_data;
    end
  end

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_vld); // R10
endmodule

// File: rtl/dsr_status_top.sv
`timescale 1ns/1ps
module dsr_status_top
  import dsr_pkg::*;
#(
  parameter int NDRV = 2,
  localparam int DW  = (NDRV > 1) ? $clog2(NDRV) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NDRV-1:0] drv_present,
  input  logic            ev_vld,
  input  logic [DW-1:0]   ev_drv,
  input  logic [2:0]      ev_code,
  input  logic            rd_req,
  input  logic [DW-1:0]   rd_drv,
  output logic            rd_vld,
  output logic [7:0]      rd_data
);
  logic [NDRV-1:0][SW-1:0] stat_all;

  for (genvar g = 0; g < NDRV; g++) begin : g_drv
    dsr_drive_reg u_reg (
      .clk     (clk),
      .rst     (rst),
      .present (drv_present[g]),
      .ev_hit  (ev_vld && ev_drv == DW'(g)),
      .ev_code (ev_code_e'(ev_code)),
      .rd_hit  (rd_req && rd_drv == DW'(g)),
      .stat    (stat_all[g])
    );
  end

  dsr_read_port #(.NDRV(NDRV), .DW(DW)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_req   (rd_req),
    .rd_drv   (rd_drv),
    .stat_all (stat_all),
    .rd_vld   (rd_vld),
    .rd_data  (rd_data)
  );
endmodule

// File: tb/dsr_status_top_tb_top.sv
`timescale 1ns/1ps
module dsr_status_top_tb_top;
  localparam int NDRV = 2;
  localparam int DW   = 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NDRV-1:0] drv_present = '1;
  logic            ev_vld = 1'b0;
  logic [DW-1:0]   ev_drv = '0;
  logic [2:0]      ev_code = '0;
  logic            rd_req = 1'b0;
  logic [DW-1:0]   rd_drv = '0;
  logic            rd_vld;
  logic [7:0]      rd_data;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  dsr_status_top #(.NDRV(NDRV)) dut_i (.*);

  function automatic logic [7:0] with_sum(input logic [7:0] v);
    logic [7:0] r;
    r = v & 8'hFE;
    r[0] = |(v & 8'hEA);
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic do_reset(input logic [NDRV-1:0] pres);
    drv_present = pres;
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_ev(input int d, input int code);
    ev_vld = 1'b1; ev_drv = DW'(d); ev_code = 3'(code);
    @(negedge clk);
    ev_vld = 1'b0;
  endtask

  task automatic do_read(input int d, output logic [7:0] got);
    rd_req = 1'b1; rd_drv = DW'(d);
    @(negedge clk);
    rd_req = 1'b0;
    got = rd_data;
  endtask

  // sweep bit k -> event code and status bit it sets
  function automatic int code_of(input int k);
    case (k)
      0: return 1; 1: return 3; 2: return 4;
      3: return 5; 4: return 6; default: return 7;
    endcase
  endfunction
  function automatic logic [7:0] bit_of(input int k);
    case (k)
      0: return 8'h04; 1: return 8'h02; 2: return 8'h20;
      3: return 8'h10; 4: return 8'h08; default: return 8'h80;
    endcase
  endfunction

  initial begin
    logic [7:0] got;
    logic [7:0] v;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;

    // R7 reset state, both present
    do_read(0, got); check("R7 reset present drv0", got, 8'h00);
    // R7 and R2: absent drive reads not-ready with summary
    do_reset(2'b01);
    do_read(1, got); check("R7 reset absent drv1", got, 8'h41);
    do_read(0, got); check("R7 reset present drv0", got, 8'h00);

    // Sweep: R1 R2 R4 R5 R6 R3 R9
    for (int d = 0; d < NDRV; d++) begin
      for (int m = 0; m < 64; m++) begin
        do_reset(2'b11);
        v = 8'h00;
        for (int k = 0; k < 6; k++)
          if (m[k]) begin
            do_ev(d, code_of(k));
            v = v | bit_of(k);
          end
        do_ev(d, 0); // R6 code 0 does nothing
        do_read(d, got); check("R1/R2/R5/R6 first read", got, with_sum(v));
        v = v & ~8'h3A;
        do_read(1 - d, got); check("R9 other drive untouched", got, 8'h00);
        do_read(d, got); check("R3 cleared on read", got, with_sum(v));
      end
    end

    // R4 busy clears on completion
    do_reset(2'b11);
    do_ev(1, 1);
    do_read(1, got); check("R4 busy set", got, 8'h04);
    do_ev(1, 2);
    do_read(1, got); check("R4 busy cleared", got, 8'h00);

    // R8 removal and installation
    do_reset(2'b11);
    drv_present = 2'b10;
    @(negedge clk);
    do_read(0, got); check("R8 removal sets not ready", got, 8'h41);
    do_read(0, got); check("R3 not ready kept after read", got, 8'h41);
    do_read(1, got); check("R9 drv1 unaffected by drv0 removal", got, 8'h00);
    drv_present = 2'b11;
    @(negedge clk);
    do_read(0, got); check("R8 install clears not ready", got, 8'h00);

    // R10 read coinciding with event, and latency
    do_reset(2'b11);
    do_ev(0, 6);
    rd_req = 1'b1; rd_drv = '0;
    ev_vld = 1'b1; ev_drv = '0; ev_code = 3'd3;
    @(negedge clk);
    rd_req = 1'b0; ev_vld = 1'b0;
    check("R10 rd_vld one cycle later", {7'd0, rd_vld}, 8'h01);
    check("R10 read returns pre-event word", rd_data, 8'h09);
    @(negedge clk);
    check("R10 rd_vld drops", {7'd0, rd_vld}, 8'h00);
    do_read(0, got); check("R10 event survives clear", got, 8'h03);

    // R7 reset clears a sticky drive identity bit
    do_ev(0, 7);
    do_reset(2'b11);
    do_read(0, got); check("R7 reset clears identity", got, 8'h00);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule